// File: doc/BRIEF.md
# Change-Detect Port Event Logger

The block samples a parallel input port as a single word on a programmable sample tick and compares each sample with the one before it. A sample that matches its predecessor is discarded. A sample that differs produces one event record. The record holds either the new port word or the mask of bits that toggled, together with a 32-bit timestamp taken from a free-running cycle counter at the sampling edge. Because every pin is captured at the same edge, there is no skew between channels. The time aperture equals the tick period.

Records go into two alternating buffers. While the host reads one full buffer as a block, the other buffer fills. A full buffer raises its ready flag, and the host hands the buffer back with a release pulse. If the block needs to write while the active buffer is still held by the host, it discards the record and sets a sticky overflow flag. The port input must already be synchronous to `clk_i`.

Top module: `port_event_logger`

## Requirements
- R1: Each sample captures all PORT_W bits of `port_i` at the same clock edge. A record's state field holds the whole word from that edge, even when many bits flip at once.
- R2: While `en_i` is high, a sample is taken on every (D+1)-th rising edge, where D = `div_i`. The count restarts when `en_i` goes low. After `en_i` rises, the first sample falls on the (D+1)-th edge.
- R3: The first sample after reset, and the first after each rise of `en_i`, only sets the comparison baseline and writes no record.
- R4: A sample that equals the previous sample writes no record. A sample that differs from it writes exactly one record.
- R5: With `rec_sel_i` = 0 the state field is the new port word. With `rec_sel_i` = 1 it is the XOR of the new word and the previous sample, so that bit i is set when pin i changed.
- R6: The timestamp counter is 0 at reset and increments on every clock. A record's time field equals the counter value at the edge where the sample was taken.
- R7: A pulse that starts and ends between two sample edges writes no record.
- R8: Records fill consecutive addresses 0..DEPTH-1 of the active buffer, and buffer 0 is active after reset. When address DEPTH-1 is written, `ready_o[b]` rises for that buffer and writing continues at address 0 of the other buffer.
- R9: A one-cycle pulse on `release_i[b]` clears `ready_o[b]` on the next edge.
- R10: If a record arrives while the active buffer's ready flag is set, the record is dropped, no buffer entry changes, and `overflow_o` goes high and stays high until reset.
- R11: After reset `ready_o` = 0 and `overflow_o` = 0.
- R12: `rd_state_o` and `rd_time_o` show entry `rd_addr_i` of buffer `rd_buf_i` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables sampling; low clears baseline and divider |
| div_i | input | DIV_W | Sample tick divisor D (period D+1 clocks) |
| rec_sel_i | input | 1 | 0: store new word, 1: store change mask |
| port_i | input | PORT_W | Monitored input port |
| release_i | input | 2 | Per-buffer release pulse from host |
| rd_buf_i | input | 1 | Buffer selected for reading |
| rd_addr_i | input | $clog2(DEPTH) | Entry selected for reading |
| rd_state_o | output | PORT_W | State field of selected entry |
| rd_time_o | output | 32 | Timestamp of selected entry |
| ready_o | output | 2 | Per-buffer full flags |
| overflow_o | output | 1 | Sticky record-dropped flag |

## Verification
The bench builds the block with PORT_W = 32, DEPTH = 4 and DIV_W = 8. The shallow depth brings a buffer switch, a double-full drop and the sticky overflow within a few dozen cycles. The full 32-bit port lets all-ones and all-zeros transitions test atomic capture. Divisors 0 and 3 are set at run time, so both every-edge sampling and a missed sub-tick pulse with a known tick phase are covered.

// File: rtl/pel_pkg.sv
package pel_pkg;
  localparam int unsigned TS_W = 32;

  typedef enum logic {
    REC_STATE = 1'b0,
    REC_DELTA = 1'b1
  } rec_sel_e;
endpackage

// File: rtl/pel_tick_div.sv
module pel_tick_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the period bounded if div_i drops below the running count
  assign tick_o = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i != $past(div_i)));

  a_r2_no_tick_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
endmodule

// File: rtl/pel_change_det.sv
module pel_change_det
  import pel_pkg::*;
#(
  parameter int unsigned PORT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  rec_sel_e          rec_sel_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              evt_vld_o,
  output logic [PORT_W-1:0] evt_state_o,
  output logic [TS_W-1:0]   evt_time_o
);
  logic [PORT_W-1:0] samp_q;
  logic              base_vld_q;
  logic [PORT_W-1:0] diff;
  logic              evt_vld_q;
  logic [PORT_W-1:0] evt_state_q;
  logic [TS_W-1:0]   evt_time_q;

  assign diff = port_i ^ samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q      <= '0;
      base_vld_q  <= 1'b0;
      evt_vld_q   <= 1'b0;
      evt_state_q <= '0;
      evt_time_q  <= '0;
    end else begin
      evt_vld_q <= 1'b0;
      if (!en_i) base_vld_q <= 1'b0;
      if (tick_i) begin
        samp_q     <= port_i;
        base_vld_q <= 1'b1;
        if (base_vld_q && (|diff)) begin
          evt_vld_q   <= 1'b1;
          evt_state_q <= (rec_sel_i == REC_DELTA) ? diff : port_i;
          evt_time_q  <= ts_i;
        end
      end
    end
  end

  assign evt_vld_o   = evt_vld_q;
  assign evt_state_o = evt_state_q;
  assign evt_time_o  = evt_time_q;

  a_r4_evt_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !evt_vld_o);

  a_r3_baseline_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !base_vld_q) |=> !evt_vld_o);

  a_r4_quiet_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && port_i == samp_q) |=> !evt_vld_o);
endmodule

// File: rtl/pel_pingpong.sv
module pel_pingpong
  import pel_pkg::*;
#(
  parameter int unsigned PORT_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_vld_i,
  input  logic [PORT_W-1:0] evt_state_i,
  input  logic [TS_W-1:0]   evt_time_i,
  input  logic [1:0]        release_i,
  input  logic              rd_buf_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [PORT_W-1:0] rd_state_o,
  output logic [TS_W-1:0]   rd_time_o,
  output logic [1:0]        ready_o,
  output logic              overflow_o
);
  logic          wr_sel_q;
  logic [AW-1:0] wr_ptr_q;
  logic [1:0]    ready_q, ready_n;
  logic          ovf_q;
  logic          accept, last;

  logic [PORT_W-1:0] bank_state [2];
  logic [TS_W-1:0]   bank_time  [2];

  assign accept = evt_vld_i && !ready_q[wr_sel_q];
  assign last   = (wr_ptr_q == AW'(DEPTH-1));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [PORT_W-1:0] st_mem [DEPTH];
    logic [TS_W-1:0]   tm_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (accept && (wr_sel_q == 1'(b))) begin
        st_mem[wr_ptr_q] <= evt_state_i;
        tm_mem[wr_ptr_q] <= evt_time_i;
      end
    end

    assign bank_state[b] = st_mem[rd_addr_i];
    assign bank_time[b]  = tm_mem[rd_addr_i];
  end

  always_comb begin
    ready_n = ready_q & ~release_i;
    if (accept && last) ready_n[wr_sel_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_sel_q <= 1'b0;
      wr_ptr_q <= '0;
      ready_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      ready_q <= ready_n;
      if (accept) begin
        if (last) begin
          wr_ptr_q <= '0;
          wr_sel_q <= ~wr_sel_q;
        end else begin
          wr_ptr_q <= wr_ptr_q + 1'b1;
        end
      end
      if (evt_vld_i && ready_q[wr_sel_q]) ovf_q <= 1'b1;
    end
  end

  assign rd_state_o = bank_state[rd_buf_i];
  assign rd_time_o  = bank_time[rd_buf_i];
  assign ready_o    = ready_q;
  assign overflow_o = ovf_q;

  a_r10_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r10_drop_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && ready_q[wr_sel_q]) |=> overflow_o);

  a_r8_switch_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && last) |=> (wr_sel_q != $past(wr_sel_q) && wr_ptr_q == '0
                          && ready_o[$past(wr_sel_q)]));

  a_r9_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i[0] && !(accept && last && !wr_sel_q)) |=> !ready_o[0]);
endmodule

// File: rtl/port_event_logger.sv
module port_event_logger
  import pel_pkg::*;
#(
  parameter int unsigned PORT_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DIV_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [DIV_W-1:0]         div_i,
  input  logic                     rec_sel_i,
  input  logic [PORT_W-1:0]        port_i,
  input  logic [1:0]               release_i,
  input  logic                     rd_buf_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [PORT_W-1:0]        rd_state_o,
  output logic [TS_W-1:0]          rd_time_o,
  output logic [1:0]               ready_o,
  output logic                     overflow_o
);
  logic              tick;
  logic [TS_W-1:0]   ts_q;
  logic              evt_vld;
  logic [PORT_W-1:0] evt_state;
  logic [TS_W-1:0]   evt_time;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 1'b1;
  end

  pel_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  pel_change_det #(.PORT_W(PORT_W)) u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .tick_i      (tick),
    .rec_sel_i   (rec_sel_e'(rec_sel_i)),
    .port_i      (port_i),
    .ts_i        (ts_q),
    .evt_vld_o   (evt_vld),
    .evt_state_o (evt_state),
    .evt_time_o  (evt_time)
  );

  pel_pingpong #(.PORT_W(PORT_W), .DEPTH(DEPTH)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_vld_i   (evt_vld),
    .evt_state_i (evt_state),
    .evt_time_i  (evt_time),
    .release_i   (release_i),
    .rd_buf_i    (rd_buf_i),
    .rd_addr_i   (rd_addr_i),
    .rd_state_o  (rd_state_o),
    .rd_time_o   (rd_time_o),
    .ready_o     (ready_o),
    .overflow_o  (overflow_o)
  );

  a_r6_ts_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ts_q == $past(ts_q) + 1'b1);
endmodule

// File: tb/port_event_logger_tb_top.sv
module port_event_logger_tb_top;
  localparam int PW = 32;
  localparam int DP = 4;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          en_i;
  logic [DW-1:0] div_i;
  logic          rec_sel_i;
  logic [PW-1:0] port_i;
  logic [1:0]    release_i;
  logic          rd_buf_i;
  logic [AW-1:0] rd_addr_i;
  logic [PW-1:0] rd_state_o;
  logic [31:0]   rd_time_o;
  logic [1:0]    ready_o;
  logic          overflow_o;

  port_event_logger #(.PORT_W(PW), .DEPTH(DP), .DIV_W(DW)) dut_i (
    .clk_i, .rst_ni, .en_i, .div_i, .rec_sel_i, .port_i, .release_i,
    .rd_buf_i, .rd_addr_i, .rd_state_o, .rd_time_o, .ready_o, .overflow_o
  );

  always #2 clk_i = ~clk_i;

  int n_edges = 0;
  always @(posedge clk_i) if (rst_ni) n_edges <= n_edges + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] VEC [12] = '{
    32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001,
    32'h8000_0001, 32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0000,
    32'h0000_0000, 32'h1234_5678, 32'h1234_5679, 32'h1234_5679
  };

  logic [31:0] es [8];
  logic [31:0] et [8];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_rec(input string req, input logic b, input int a,
                         input logic [31:0] s, input logic [31:0] t);
    rd_buf_i  = b;
    rd_addr_i = AW'(a);
    #1;
    chk(req, {rd_state_o, rd_time_o}, {s, t});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int ne;
    logic [31:0] t1, t2, t11;
    logic [31:0] ot [5];
    rst_ni = 1'b0; en_i = 1'b0; div_i = '0; rec_sel_i = 1'b0;
    port_i = '0; release_i = '0; rd_buf_i = 1'b0; rd_addr_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R11 ready", 64'(ready_o), 64'h0);
    chk("R11 overflow", 64'(overflow_o), 64'h0);

    // vector walk, divisor 0: every edge samples, first is baseline
    ne = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      if (i == 0) en_i = 1'b1;
      port_i = VEC[i];
      if (i > 0 && VEC[i] != VEC[i-1]) begin
        es[ne] = VEC[i];
        et[ne] = n_edges;
        ne++;
      end
    end
    @(negedge clk_i); en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R8 ready after one buffer", 64'(ready_o), 64'h1);
    chk("R10 no overflow", 64'(overflow_o), 64'h0);
    for (int a = 0; a < 4; a++) chk_rec("R1 R4 R6 R12 buffer0", 1'b0, a, es[a], et[a]);
    for (int a = 0; a < 2; a++) chk_rec("R8 R4 buffer1", 1'b1, a, es[4+a], et[4+a]);

    @(negedge clk_i); release_i = 2'b01;
    @(negedge clk_i); release_i = 2'b00;
    #1;
    chk("R9 release", 64'(ready_o), 64'h0);

    // change-mask mode, baseline after re-enable
    port_i = 32'hAAAA_0000; rec_sel_i = 1'b1;
    @(negedge clk_i); en_i = 1'b1;
    @(negedge clk_i); port_i = 32'hAAAA_0006; t1 = n_edges;
    @(negedge clk_i); port_i = 32'h0000_0006; t2 = n_edges;
    @(negedge clk_i); en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk_rec("R3 R5 mask", 1'b1, 2, 32'h0000_0006, t1);
    chk_rec("R5 mask", 1'b1, 3, 32'hAAAA_0000, t2);
    chk("R8 buffer1 full", 64'(ready_o), 64'h2);

    // fill buffer0, then one more record with both held
    rec_sel_i = 1'b0;
    @(negedge clk_i); en_i = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk_i); port_i = 32'(k); ot[k-1] = n_edges;
    end
    @(negedge clk_i); en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R10 overflow set", 64'(overflow_o), 64'h1);
    chk("R10 both ready", 64'(ready_o), 64'h3);
    for (int a = 0; a < 4; a++) chk_rec("R8 buffer0 refill", 1'b0, a, 32'(a+1), ot[a]);
    chk_rec("R10 buffer1 untouched", 1'b1, 0, es[4], et[4]);
    chk_rec("R10 buffer1 tail untouched", 1'b1, 3, 32'hAAAA_0000, t2);
    @(negedge clk_i); release_i = 2'b11;
    @(negedge clk_i); release_i = 2'b00;
    #1;
    chk("R9 release both", 64'(ready_o), 64'h0);
    chk("R10 sticky", 64'(overflow_o), 64'h1);

    // divisor 3: samples on edges 3,7,11; pulse on edge 5 only is missed
    div_i = 8'd3;
    t11 = '0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk_i);
      if (k == 0) en_i = 1'b1;
      port_i = (k == 5) ? 32'h0000_F001 : (k >= 8) ? 32'h0F00_F000 : 32'h0000_F000;
      if (k == 11) t11 = n_edges;
    end
    @(negedge clk_i); en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk_rec("R2 R7 divided sample", 1'b1, 0, 32'h0F00_F000, t11);
    chk("R2 no buffer full", 64'(ready_o), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule